// File: doc/BRIEF.md
# Programmable Aperture Address Remapper

This block sits on the address path of one bus master. It cuts the 32-bit master address space into sixteen 256 MB apertures, with the top address nibble choosing the aperture. Each aperture has a small programmable entry. The entry names the slave port that receives the access. It also names the nibble that replaces the top four address bits before the address reaches that slave. The low 28 address bits pass through unchanged.

Each master gets its own instance, so different masters can hold different maps. Software writes entries through a simple register port and can read them back at any time. Out of reset, the two highest apertures already lead to the two peripheral bridges, rebased to address zero. All other apertures start unmapped.

The decode result is registered in a three-state result register:
- `RES_IDLE`: no access was presented.
- `RES_ROUTE`: the access was routed to a slave.
- `RES_FAULT`: the access hit an unmapped aperture.

Every cycle the register moves to one of these states from any state:
- to `RES_ROUTE` when a valid address hits a mapped aperture;
- to `RES_FAULT` when a valid address hits an unmapped aperture;
- to `RES_IDLE` when no valid address is presented.

Top module: `apr_remap`

## Requirements
- R1: After reset, with no programming, a master address 0xF000_0000..0xFFFF_FFFF routes to slave code 0 (local peripheral bridge) with top nibble 0 in the slave address.
- R2: After reset, a master address 0xE000_0000..0xEFFF_FFFF routes to slave code 1 (second peripheral bridge) with top nibble 0 in the slave address.
- R3: After reset, apertures 0x0..0xD hold slave code 15, the unmapped code. A valid access there gives `s_err`=1, `s_valid`=0, `s_sel`=15 and `s_addr`=0.
- R4: For a routed access, `s_addr` equals the aperture's replacement nibble followed by master address bits [27:0].
- R5: The decode outputs appear exactly one clock after `m_valid`. In a cycle after no valid input, `s_valid`, `s_err`, `s_sel` and `s_addr` are all zero.
- R6: A configuration entry is 8 bits, with slave code in bits [3:0] and replacement nibble in bits [7:4]. `cfg_wr` writes `cfg_wdata` to entry `cfg_idx`. `cfg_rdata` shows entry `cfg_idx` combinationally.
- R7: A write takes effect at the clock edge that samples it. An access presented in the same cycle as a write decodes with the old entry.
- R8: An aperture programmed with its own index as replacement nibble passes the address through unchanged, for example aperture 0xD to tunnel slave code 2.
- R9: Reprogramming an aperture, including the reset-default 0xE and 0xF ones, replaces its mapping and leaves every other aperture unchanged.
- R10: `s_valid` and `s_err` are never both high, and `s_valid` never carries the unmapped code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Entry write strobe |
| cfg_idx | input | 4 | Aperture index for write and read |
| cfg_wdata | input | 8 | Entry to write: {nibble, slave code} |
| cfg_rdata | output | 8 | Entry currently held at cfg_idx |
| m_valid | input | 1 | Master address valid |
| m_addr | input | 32 | Master address |
| s_valid | output | 1 | Registered: access routed |
| s_err | output | 1 | Registered: access hit an unmapped aperture |
| s_sel | output | 4 | Registered slave code |
| s_addr | output | 32 | Registered translated slave address |

## Verification
The assertions take `m_valid` and `cfg_wr` to be known, non-X values whenever reset is released. They take `cfg_idx` to be meaningful only while `cfg_wr` is high. The bench drives every input on the falling clock edge and holds it through the next rising edge. It parks `cfg_wr` and `m_valid` low between operations. The one exception is the deliberate overlap case for R7, where both are high in the same cycle.

// File: rtl/apr_pkg.sv
package apr_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
    localparam int SEL_W  = 4;
    localparam int N_AP   = 1 << IDX_W;
    localparam int LOW_W  = ADDR_W - IDX_W;
    localparam int ENT_W  = IDX_W + SEL_W;

    localparam logic [SEL_W-1:0] SEL_LOCAL = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_MAIN  = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_NONE  = {SEL_W{1'b1}};

    typedef struct packed {
        logic [IDX_W-1:0] nib;
        logic [SEL_W-1:0] sel;
    } ap_entry_t;

    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_ROUTE = 2'd1,
        RES_FAULT = 2'd2
    } res_state_t;

    function automatic ap_entry_t reset_entry(int idx);
        ap_entry_t e;
        e.nib = '0;
        if (idx == N_AP - 1)      e.sel = SEL_LOCAL;
        else if (idx == N_AP - 2) e.sel = SEL_MAIN;
        else                      e.sel = SEL_NONE;
        return e;
    endfunction
endpackage

// File: rtl/apr_map_bank.sv
module apr_map_bank
    import apr_pkg::*;
#(
    parameter int APS = N_AP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(APS)-1:0]   wr_idx,
    input  ap_entry_t                wr_entry,
    input  logic [$clog2(APS)-1:0]   lk_idx,
    output ap_entry_t                lk_entry,
    output ap_entry_t                rd_entry
);
    ap_entry_t table_q [APS];

    for (genvar i = 0; i < APS; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                table_q[i] <= reset_entry(i);
            else if (wr_en && wr_idx == i)
                table_q[i] <= wr_entry;
        end
    end

    assign lk_entry = table_q[lk_idx];
    assign rd_entry = table_q[wr_idx];

    // R6 R7: a write lands in its entry at the sampling edge
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> table_q[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/apr_xlate.sv
module apr_xlate
    import apr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_in,
    input  ap_entry_t         entry,
    output logic              hit,
    output logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr_out
);
    always_comb begin
        hit      = (entry.sel != SEL_NONE);
        sel      = entry.sel;
        addr_out = {entry.nib, addr_in[LOW_W-1:0]};
    end
endmodule

// File: rtl/apr_remap.sv
module apr_remap
    import apr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ENT_W-1:0]  cfg_wdata,
    output logic [ENT_W-1:0]  cfg_rdata,
    input  logic              m_valid,
    input  logic [ADDR_W-1:0] m_addr,
    output logic              s_valid,
    output logic              s_err,
    output logic [SEL_W-1:0]  s_sel,
    output logic [ADDR_W-1:0] s_addr
);
    ap_entry_t        lk_entry;
    ap_entry_t        rd_entry;
    logic             x_hit;
    logic [SEL_W-1:0] x_sel;
    logic [ADDR_W-1:0] x_addr;

    res_state_t        state_q, state_d;
    logic [SEL_W-1:0]  sel_q, sel_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    apr_map_bank #(.APS(N_AP)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_idx   (cfg_idx),
        .wr_entry (ap_entry_t'(cfg_wdata)),
        .lk_idx   (m_addr[ADDR_W-1 -: IDX_W]),
        .lk_entry (lk_entry),
        .rd_entry (rd_entry)
    );

    apr_xlate u_xlate (
        .addr_in  (m_addr),
        .entry    (lk_entry),
        .hit      (x_hit),
        .sel      (x_sel),
        .addr_out (x_addr)
    );

    assign cfg_rdata = rd_entry;

    // next-state and payload selection
    always_comb begin
        if (!m_valid)   state_d = RES_IDLE;
        else if (x_hit) state_d = RES_ROUTE;
        else            state_d = RES_FAULT;
        unique case (state_d)
            RES_ROUTE: begin sel_d = x_sel;    addr_d = x_addr; end
            RES_FAULT: begin sel_d = SEL_NONE; addr_d = '0;     end
            default:   begin sel_d = '0;       addr_d = '0;     end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            sel_q   <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            addr_q  <= addr_d;
        end
    end

    // outputs
    always_comb begin
        s_sel  = sel_q;
        s_addr = addr_q;
        unique case (state_q)
            RES_ROUTE: begin s_valid = 1'b1; s_err = 1'b0; end
            RES_FAULT: begin s_valid = 1'b0; s_err = 1'b1; end
            default:   begin s_valid = 1'b0; s_err = 1'b0; end
        endcase
    end

    // R5: one-cycle latency from valid input to a result
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |=> (s_valid || s_err));
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !m_valid |=> (!s_valid && !s_err && s_addr == '0));
    // R10: exclusive result, no routing on the unmapped code
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_err));
    a_r10_no_none_route: assert property (@(posedge clk) disable iff (!rst_n)
        s_valid |-> s_sel != SEL_NONE);
    // R4: low bits pass through on a routed access
    a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |=> (!s_valid || s_addr[LOW_W-1:0] == $past(m_addr[LOW_W-1:0])));
    // R3: a fault presents the unmapped code and a zero address
    a_r3_fault_payload: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |-> (s_sel == SEL_NONE && s_addr == '0));
endmodule

// File: tb/test_apr_remap.sv
`timescale 1ns/1ps
module test_apr_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        m_valid = 1'b0;
    logic [31:0] m_addr = '0;
    logic        s_valid, s_err;
    logic [3:0]  s_sel;
    logic [31:0] s_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    apr_remap i_apr_remap (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_valid(m_valid),
        .m_addr(m_addr), .s_valid(s_valid), .s_err(s_err), .s_sel(s_sel),
        .s_addr(s_addr)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_route(string req, logic [31:0] a, logic [3:0] sel, logic [31:0] sa);
        @(negedge clk); m_valid = 1'b1; m_addr = a;
        @(negedge clk); m_valid = 1'b0;
        check(req, {s_valid, s_err, s_sel, s_addr}, {1'b1, 1'b0, sel, sa});
    endtask

    task automatic expect_fault(string req, logic [31:0] a);
        @(negedge clk); m_valid = 1'b1; m_addr = a;
        @(negedge clk); m_valid = 1'b0;
        check(req, {s_valid, s_err, s_sel, s_addr}, {1'b0, 1'b1, 4'hF, 32'h0});
    endtask

    task automatic write_entry(logic [3:0] idx, logic [3:0] nib, logic [3:0] sel);
        @(negedge clk); cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = {nib, sel};
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R5 reset outputs", {s_valid, s_err, s_sel, s_addr}, '0);
        cfg_idx = 4'hF; #1 check("R1 reset entry F", cfg_rdata, 8'h00);
        cfg_idx = 4'hE; #1 check("R2 reset entry E", cfg_rdata, 8'h01);
        cfg_idx = 4'h3; #1 check("R3 reset entry 3", cfg_rdata, 8'h0F);
    endtask

    task automatic t_defaults;
        expect_route("R1 F lo", 32'hF000_0000, 4'd0, 32'h0000_0000);
        expect_route("R1 F hi", 32'hFFFF_FFFF, 4'd0, 32'h0FFF_FFFF);
        expect_route("R2 E",    32'hE123_4567, 4'd1, 32'h0123_4567);
        expect_route("R2 E hi", 32'hEFFF_FFFC, 4'd1, 32'h0FFF_FFFC);
        expect_fault("R3 aperture 0", 32'h0000_1000);
        expect_fault("R3 aperture D", 32'hD000_0010);
    endtask

    task automatic t_idle;
        @(negedge clk); m_valid = 1'b0; m_addr = 32'hF555_5555;
        @(negedge clk);
        check("R5 idle after no valid", {s_valid, s_err, s_sel, s_addr}, '0);
        expect_route("R5 back-to-back a", 32'hF000_0004, 4'd0, 32'h0000_0004);
        @(negedge clk);
        check("R5 idle follows access", {s_valid, s_err}, 2'b00);
    endtask

    task automatic t_program;
        write_entry(4'hD, 4'hD, 4'd2);
        cfg_idx = 4'hD; #1 check("R6 readback D", cfg_rdata, 8'hD2);
        expect_route("R8 D identity", 32'hD000_0000, 4'd2, 32'hD000_0000);
        expect_route("R8 D top",      32'hDFFF_FFFF, 4'd2, 32'hDFFF_FFFF);
        write_entry(4'h4, 4'h8, 4'd5);
        expect_route("R4 rebase 4->8", 32'h4ABC_DEF0, 4'd5, 32'h8ABC_DEF0);
        cfg_idx = 4'h5; #1 check("R9 neighbour untouched", cfg_rdata, 8'h0F);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 4'hF; cfg_wdata = {4'h3, 4'd7};
        m_valid = 1'b1; m_addr = 32'hF000_0100;
        @(negedge clk);
        cfg_wr = 1'b0; m_valid = 1'b0;
        check("R7 same-cycle old map", {s_valid, s_sel, s_addr}, {1'b1, 4'd0, 32'h0000_0100});
        expect_route("R7 next access new map", 32'hF000_0100, 4'd7, 32'h3000_0100);
        expect_route("R9 E still default", 32'hE000_0200, 4'd1, 32'h0000_0200);
        write_entry(4'hE, 4'h0, 4'hF);
        expect_fault("R9 E unmapped by write", 32'hE000_0000);
        expect_route("R9 D kept", 32'hD000_0008, 4'd2, 32'hD000_0008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_defaults();
        t_idle();
        t_program();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule